// File: doc/BRIEF.md
# Banked Register File with Indirect Access

This block is the data-memory front end of a small 8-bit core. A 7-bit direct address from the instruction picks an offset. The bank bit held in the status register picks one of two banks, so the full data space is 256 bytes. Sixty-four general-purpose bytes appear at the same offsets in both banks. A small set of peripheral stub registers sits low in each bank, and each bank has its own copy of them. Every other location reads as zero and ignores writes.

Offset 00h is a phantom register. Any access to it is redirected to the location named by the pointer register. The effective indirect address is nine bits wide: a high bit taken from status bit 7 above the 8-bit pointer. The status register merges three sources: instruction writes, flag updates from the ALU (one write-enable per flag), and reset-cause events from the watchdog and power-down logic. The time-out and power-down bits cannot be written by instructions. When the ALU updates any flag in the same cycle as an instruction write to status, the three flag bits are taken from the ALU and not from the written data.

The block classifies each access into one of six regions (unimplemented, phantom, status, pointer, general RAM, stub). A unique case over that region selects the read source and the write target. Reads are registered, and writes take effect at the clock edge.

Top module: `rf_banked_top`

## Requirements
- R1: After reset, status reads 18h (time-out bit 4 and power-down bit 3 set, all other bits 0), the pointer reads 00h and rd_data is 00h.
- R2: Status bit 5 selects the bank (0 gives bank 0, 1 gives bank 1). Stub offsets 05h–08h hold separate storage in each bank.
- R3: Offsets 20h–5Fh reach the same 64 bytes of RAM from either bank.
- R4: All other offsets read 00h, and writes to them change no implemented location. This covers 01h, 02h, 09h–1Fh and 60h–7Fh.
- R5: Status (offset 03h) and the pointer (offset 04h) are the same registers in both banks.
- R6: Offset 00h reads and writes the location given by the pointer: pointer bit 7 is the bank and bits 6:0 the offset. When the pointer names offset 00h of either bank, a read returns 00h and a write has no effect.
- R7: Status bit 7 is bit 8 of the indirect address. While it is 1, an indirect read returns 00h and an indirect write has no effect.
- R8: An instruction write to status loads bits 7:5 from the data. If any flag write-enable (flag_we[2]=Z, [1]=DC, [0]=C) is set in that cycle, bits 2:0 ignore the data: enabled flags take flag_val and the others keep their value.
- R9: Bits 4:3 ignore instruction writes. evt_timeout clears bit 4. evt_sleep sets bit 4 and clears bit 3. evt_wdt_clear sets both. evt_timeout has priority over the other two and then leaves bit 3 unchanged.
- R10: rd_data changes only on the clock edge where rd_en is high. A read in the same cycle as a write to the same location returns the old value.
- R11: A flag update with no status write loads each enabled flag from flag_val and leaves the other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 7 | Direct offset within the selected bank |
| rd_en | input | 1 | Read strobe; result appears on rd_data after the edge |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| flag_we | input | 3 | ALU flag write-enables {Z, DC, C} |
| flag_val | input | 3 | ALU flag values {Z, DC, C} |
| evt_timeout | input | 1 | Watchdog expiry event |
| evt_sleep | input | 1 | Power-down entry event |
| evt_wdt_clear | input | 1 | Watchdog clear event |

## Verification
The bench builds the block with its default parameters: general RAM at offsets 20h–5Fh and four stubs per bank at 05h–08h. With these values the bench can probe every region edge directly (1Fh/20h, 5Fh/60h, 04h/05h, 08h/09h) from both banks. A 7-bit pointer offset is enough to reach the phantom register, status, the stubs and shared RAM indirectly. This exercises the full nine-bit path, including the case where the high bit is set.

// File: rtl/rf_pkg.sv
package rf_pkg;

    typedef enum logic [2:0] {
        RG_UNIMP,
        RG_PHANTOM,
        RG_STATUS,
        RG_POINTER,
        RG_GPR,
        RG_STUB
    } rf_region_e;

    // status bit positions (the bank bit and indirect-high bit are decoded)
    localparam int SB_IHI  = 7;
    localparam int SB_BANK = 5;
    localparam int SB_TO   = 4;
    localparam int SB_PD   = 3;

    localparam logic [6:0] OFF_PHANTOM = 7'h00;
    localparam logic [6:0] OFF_STATUS  = 7'h03;
    localparam logic [6:0] OFF_POINTER = 7'h04;

    localparam logic [7:0] STATUS_RST  = 8'h18;

endpackage

// File: rtl/rf_addr_decode.sv
module rf_addr_decode
    import rf_pkg::*;
#(
    parameter int GPR_BASE   = 32,
    parameter int GPR_DEPTH  = 64,
    parameter int STUB_BASE  = 5,
    parameter int STUB_COUNT = 4,
    localparam int GPR_IW    = $clog2(GPR_DEPTH),
    localparam int STUB_IW   = $clog2(2 * STUB_COUNT)
) (
    input  logic [6:0]         dir_addr,
    input  logic               bank_sel,
    input  logic               ind_hi,
    input  logic [7:0]         ptr,
    output rf_region_e         region,
    output logic [GPR_IW-1:0]  gpr_idx,
    output logic [STUB_IW-1:0] stub_idx
);

    localparam int SOFF_W = STUB_IW - 1;

    logic       use_ind;
    logic       eff_hi;
    logic       eff_bank;
    logic [6:0] eff_off;

    always_comb begin
        use_ind  = (dir_addr == OFF_PHANTOM);
        eff_hi   = use_ind ? ind_hi : 1'b0;
        eff_bank = use_ind ? ptr[7] : bank_sel;
        eff_off  = use_ind ? ptr[6:0] : dir_addr;

        gpr_idx  = GPR_IW'(eff_off - 7'(GPR_BASE));
        stub_idx = {eff_bank, SOFF_W'(eff_off - 7'(STUB_BASE))};

        if (eff_hi) begin
            region = RG_UNIMP;
        end else if (eff_off == OFF_PHANTOM) begin
            region = RG_PHANTOM;
        end else if (eff_off == OFF_STATUS) begin
            region = RG_STATUS;
        end else if (eff_off == OFF_POINTER) begin
            region = RG_POINTER;
        end else if (int'(eff_off) >= GPR_BASE &&
                     int'(eff_off) <  GPR_BASE + GPR_DEPTH) begin
            region = RG_GPR;
        end else if (int'(eff_off) >= STUB_BASE &&
                     int'(eff_off) <  STUB_BASE + STUB_COUNT) begin
            region = RG_STUB;
        end else begin
            region = RG_UNIMP;
        end
    end

endmodule

// File: rtl/rf_byte_store.sv
module rf_byte_store #(
    parameter int  DEPTH          = 64,
    parameter int  WIDTH          = 8,
    parameter bit  CLEAR_ON_RESET = 1'b0,
    localparam int IW             = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IW-1:0]    idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    generate
        if (CLEAR_ON_RESET) begin : g_clr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        mem[i] <= '0;
                    end
                end else if (we) begin
                    mem[idx] <= wdata;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (we && rst_n) begin
                    mem[idx] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata = mem[idx];

endmodule

// File: rtl/rf_status_reg.sv
module rf_status_reg
    import rf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [2:0] flag_we,
    input  logic [2:0] flag_val,
    input  logic       evt_timeout,
    input  logic       evt_sleep,
    input  logic       evt_wdt_clear,
    output logic [7:0] q
);

    logic [7:0] nxt;

    always_comb begin
        nxt = q;
        if (wr_en) begin
            nxt[7:5] = wr_data[7:5];
            if (flag_we == 3'b000) begin
                nxt[2:0] = wr_data[2:0];
            end
        end
        for (int i = 0; i < 3; i++) begin
            if (flag_we[i]) begin
                nxt[i] = flag_val[i];
            end
        end
        if (evt_timeout) begin
            nxt[SB_TO] = 1'b0;
        end else if (evt_sleep) begin
            nxt[SB_TO] = 1'b1;
            nxt[SB_PD] = 1'b0;
        end else if (evt_wdt_clear) begin
            nxt[SB_TO] = 1'b1;
            nxt[SB_PD] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= STATUS_RST;
        end else begin
            q <= nxt;
        end
    end

    // R9: without an event, bits 4:3 stay put whatever is written
    p_topd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_timeout || evt_sleep || evt_wdt_clear) |=> $stable(q[4:3]));

    // R9: a time-out always leaves bit 4 clear
    p_timeout_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_timeout |=> !q[SB_TO]);

    // R8: an enabled flag lands from the ALU
    p_flag_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we[2] |=> q[2] == $past(flag_val[2]));

    // R8: a written but non-enabled flag keeps its value when any flag updates
    p_flag_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (flag_we != 3'b000) && !flag_we[0]) |=> q[0] == $past(q[0]));

endmodule

// File: rtl/rf_banked_top.sv
module rf_banked_top
    import rf_pkg::*;
#(
    parameter int GPR_BASE   = 32,
    parameter int GPR_DEPTH  = 64,
    parameter int STUB_BASE  = 5,
    parameter int STUB_COUNT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] addr,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic [2:0] flag_we,
    input  logic [2:0] flag_val,
    input  logic       evt_timeout,
    input  logic       evt_sleep,
    input  logic       evt_wdt_clear
);

    localparam int GPR_IW  = $clog2(GPR_DEPTH);
    localparam int STUB_IW = $clog2(2 * STUB_COUNT);

    rf_region_e         region;
    logic [GPR_IW-1:0]  gpr_idx;
    logic [STUB_IW-1:0] stub_idx;
    logic [7:0]         status_q;
    logic [7:0]         ptr_q;
    logic [7:0]         gpr_rd;
    logic [7:0]         stub_rd;
    logic [7:0]         rd_mux;
    logic               we_status;
    logic               we_ptr;
    logic               we_gpr;
    logic               we_stub;

    rf_addr_decode #(
        .GPR_BASE   (GPR_BASE),
        .GPR_DEPTH  (GPR_DEPTH),
        .STUB_BASE  (STUB_BASE),
        .STUB_COUNT (STUB_COUNT)
    ) u_dec (
        .dir_addr (addr),
        .bank_sel (status_q[SB_BANK]),
        .ind_hi   (status_q[SB_IHI]),
        .ptr      (ptr_q),
        .region   (region),
        .gpr_idx  (gpr_idx),
        .stub_idx (stub_idx)
    );

    always_comb begin
        we_status = 1'b0;
        we_ptr    = 1'b0;
        we_gpr    = 1'b0;
        we_stub   = 1'b0;
        rd_mux    = 8'h00;
        unique case (region)
            RG_STATUS: begin
                we_status = wr_en;
                rd_mux    = status_q;
            end
            RG_POINTER: begin
                we_ptr = wr_en;
                rd_mux = ptr_q;
            end
            RG_GPR: begin
                we_gpr = wr_en;
                rd_mux = gpr_rd;
            end
            RG_STUB: begin
                we_stub = wr_en;
                rd_mux  = stub_rd;
            end
            RG_PHANTOM: rd_mux = 8'h00;
            RG_UNIMP:   rd_mux = 8'h00;
            default:    rd_mux = 8'h00;
        endcase
    end

    rf_status_reg u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (we_status),
        .wr_data       (wr_data),
        .flag_we       (flag_we),
        .flag_val      (flag_val),
        .evt_timeout   (evt_timeout),
        .evt_sleep     (evt_sleep),
        .evt_wdt_clear (evt_wdt_clear),
        .q             (status_q)
    );

    rf_byte_store #(
        .DEPTH          (GPR_DEPTH),
        .WIDTH          (8),
        .CLEAR_ON_RESET (1'b0)
    ) u_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_gpr),
        .idx   (gpr_idx),
        .wdata (wr_data),
        .rdata (gpr_rd)
    );

    rf_byte_store #(
        .DEPTH          (2 * STUB_COUNT),
        .WIDTH          (8),
        .CLEAR_ON_RESET (1'b1)
    ) u_stub (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_stub),
        .idx   (stub_idx),
        .wdata (wr_data),
        .rdata (stub_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= 8'h00;
        end else if (we_ptr) begin
            ptr_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= 8'h00;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end

    // R4: a write reaches at most one storage target
    p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_status, we_ptr, we_gpr, we_stub}));

    // R4: an unimplemented read returns zero
    p_unimp_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && region == RG_UNIMP) |=> rd_data == 8'h00);

    // R6: reading the phantom through itself returns zero
    p_phantom_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && region == RG_PHANTOM) |=> rd_data == 8'h00);

    // R6: a write that lands on the phantom leaves the pointer alone
    p_phantom_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == RG_PHANTOM) |=> $stable(ptr_q));

    // R10: read data holds without a read strobe
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/sim_rf_banked_top.sv
module sim_rf_banked_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [2:0] flag_we = '0;
    logic [2:0] flag_val = '0;
    logic       evt_timeout = 1'b0;
    logic       evt_sleep = 1'b0;
    logic       evt_wdt_clear = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rf_banked_top u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr          (addr),
        .rd_en         (rd_en),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .flag_we       (flag_we),
        .flag_val      (flag_val),
        .evt_timeout   (evt_timeout),
        .evt_sleep     (evt_sleep),
        .evt_wdt_clear (evt_wdt_clear)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d,
                      input logic [2:0] fwe = 3'b000, input logic [2:0] fv = 3'b000);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1; flag_we = fwe; flag_val = fv;
        @(negedge clk);
        wr_en = 1'b0; flag_we = 3'b000; flag_val = 3'b000;
    endtask

    task automatic flags_only(input logic [2:0] fwe, input logic [2:0] fv);
        @(negedge clk);
        flag_we = fwe; flag_val = fv;
        @(negedge clk);
        flag_we = 3'b000; flag_val = 3'b000;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic rd_chk(input string req, input logic [6:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        check("R1 rd_data", rd_data, 8'h00);
        rd_chk("R1 status", 7'h03, 8'h18);
        rd_chk("R1 pointer", 7'h04, 8'h00);
    endtask

    task automatic t_gpr_shared;
        wr(7'h20, 8'hA5);
        wr(7'h5F, 8'h3C);
        wr(7'h03, 8'h20);                       // select bank 1
        rd_chk("R2 bank bit set", 7'h03, 8'h38);
        rd_chk("R3 low edge bank1", 7'h20, 8'hA5);
        rd_chk("R3 high edge bank1", 7'h5F, 8'h3C);
        wr(7'h40, 8'h77);
        wr(7'h03, 8'h00);
        rd_chk("R3 bank1 write seen in bank0", 7'h40, 8'h77);
    endtask

    task automatic t_banked_stubs;
        wr(7'h05, 8'h11);
        wr(7'h08, 8'h44);
        wr(7'h03, 8'h20);
        wr(7'h05, 8'h22);
        rd_chk("R2 stub bank1", 7'h05, 8'h22);
        rd_chk("R2 stub bank1 untouched", 7'h08, 8'h00);
        wr(7'h03, 8'h00);
        rd_chk("R2 stub bank0", 7'h05, 8'h11);
        rd_chk("R2 stub bank0 edge", 7'h08, 8'h44);
    endtask

    task automatic t_unimp;
        wr(7'h1F, 8'hFF);
        rd_chk("R4 1Fh", 7'h1F, 8'h00);
        wr(7'h60, 8'hFF);
        rd_chk("R4 60h", 7'h60, 8'h00);
        rd_chk("R4 neighbour 5Fh intact", 7'h5F, 8'h3C);
        wr(7'h09, 8'hEE);
        rd_chk("R4 09h", 7'h09, 8'h00);
        rd_chk("R4 neighbour 08h intact", 7'h08, 8'h44);
        rd_chk("R4 02h", 7'h02, 8'h00);
        rd_chk("R4 7Fh", 7'h7F, 8'h00);
    endtask

    task automatic t_core_both;
        wr(7'h03, 8'h20);
        wr(7'h04, 8'h2A);
        wr(7'h03, 8'h00);
        rd_chk("R5 pointer shared", 7'h04, 8'h2A);
        rd_chk("R5 status shared", 7'h03, 8'h18);
    endtask

    task automatic t_indirect;
        wr(7'h04, 8'h25);
        wr(7'h00, 8'h9C);
        rd_chk("R6 indirect write", 7'h25, 8'h9C);
        wr(7'h04, 8'hA5);                       // bank1 offset 25h
        rd_chk("R6 indirect bank1 read", 7'h00, 8'h9C);
        wr(7'h04, 8'h85);                       // bank1 stub 05h
        rd_chk("R6 indirect bank1 stub", 7'h00, 8'h22);
        wr(7'h04, 8'h00);
        rd_chk("R6 phantom read", 7'h00, 8'h00);
        wr(7'h00, 8'h55);
        rd_chk("R6 phantom write pointer", 7'h04, 8'h00);
        rd_chk("R6 phantom write status", 7'h03, 8'h18);
        wr(7'h04, 8'h80);
        wr(7'h00, 8'h66);
        rd_chk("R6 phantom bank1 pointer", 7'h04, 8'h80);
    endtask

    task automatic t_ind_high;
        wr(7'h04, 8'h25);
        wr(7'h03, 8'h80);
        rd_chk("R7 high bit in status", 7'h03, 8'h98);
        rd_chk("R7 high read", 7'h00, 8'h00);
        wr(7'h00, 8'h11);
        wr(7'h03, 8'h00);
        rd_chk("R7 high write ignored", 7'h25, 8'h9C);
    endtask

    task automatic t_flags;
        flags_only(3'b111, 3'b011);
        rd_chk("R11 flag only update", 7'h03, 8'h1B);
        wr(7'h03, 8'h00, 3'b100, 3'b100);
        rd_chk("R8 flags win over write", 7'h03, 8'h1F);
        wr(7'h03, 8'h00);
        rd_chk("R9 write cannot clear bits 4:3", 7'h03, 8'h18);
        wr(7'h03, 8'h47);
        rd_chk("R8 plain write", 7'h03, 8'h5F);
        wr(7'h03, 8'h00);
        flags_only(3'b001, 3'b001);
        rd_chk("R11 single flag", 7'h03, 8'h19);
        wr(7'h03, 8'h00);
    endtask

    task automatic t_events;
        @(negedge clk); evt_sleep = 1'b1;
        @(negedge clk); evt_sleep = 1'b0;
        rd_chk("R9 sleep", 7'h03, 8'h10);
        @(negedge clk); evt_timeout = 1'b1;
        @(negedge clk); evt_timeout = 1'b0;
        rd_chk("R9 timeout", 7'h03, 8'h00);
        @(negedge clk); evt_wdt_clear = 1'b1;
        @(negedge clk); evt_wdt_clear = 1'b0;
        rd_chk("R9 clear", 7'h03, 8'h18);
        @(negedge clk); evt_timeout = 1'b1; evt_sleep = 1'b1;
        @(negedge clk); evt_timeout = 1'b0; evt_sleep = 1'b0;
        rd_chk("R9 timeout priority", 7'h03, 8'h08);
        @(negedge clk); evt_wdt_clear = 1'b1;
        @(negedge clk); evt_wdt_clear = 1'b0;
    endtask

    task automatic t_read_timing;
        logic [7:0] v;
        wr(7'h21, 8'h01);
        rd(7'h21, v);
        check("R10 read", v, 8'h01);
        repeat (3) @(negedge clk);
        check("R10 hold", rd_data, 8'h01);
        @(negedge clk);
        addr = 7'h21; wr_data = 8'h02; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R10 read before write", rd_data, 8'h01);
        rd_chk("R10 write landed", 7'h21, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gpr_shared();
        t_banked_stubs();
        t_unimp();
        t_core_both();
        t_indirect();
        t_ind_high();
        t_flags();
        t_events();
        t_read_timing();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule